// File: doc/BRIEF.md
# Configuration Space Register File with Write-One-to-Clear Bits

This block holds the byte-addressable configuration space of a PCI-style endpoint. Each byte has two fixed per-bit masks: one for ordinary read/write bits and one for write-one-to-clear bits. The two masks never share a bit. A write carries a start address, a 32-bit value and a size of one, two or four bytes. The block spreads that value over consecutive bytes, lowest lane first, and applies both masks to each byte it reaches.

Hardware raises status events on dedicated set inputs. Software later acknowledges them by writing ones. A combinational read port returns one, two or four bytes, assembled little-endian. The synchronous reset is active low. It clears only the software-controlled command bits, the cache-line-size byte and the interrupt-line byte. Every other stored byte keeps its contents across reset.

The masks and the identity bytes are fixed when the design is elaborated. An overlap between the two masks of a byte stops elaboration with an error.

Top module: `cfg_space_regfile`

## Requirements
- R1: On a write, each reached byte takes the written value in its plain-writable bits and keeps every other bit. Plain-writable bits are: byte 4 bits 2:0, byte 5 bits 2 and 0, bytes 12 and 60 entirely, and bytes 64..127 and 192..255 entirely. With no write and no set input active, no stored byte changes.
- R2: After the merge of R1, every bit that is 1 in the written byte and lies in that byte's write-one-to-clear mask is cleared. The write-one-to-clear bits are: byte 5 bit 7, byte 7 mask 0xF9, and bytes 128..131 entirely.
- R3: Bytes with neither mask never change. Bytes 0..1 read as the vendor parameter and bytes 2..3 as the device parameter, both little-endian. Byte 6 reads 0x10. All other such bytes read 0.
- R4: The size code selects the number of bytes: 0 gives one byte, 1 gives two, 2 gives four, and 3 performs no write. Lane k carries wr_data bits 8k+7..8k to address wr_addr+k.
- R5: Lanes whose address would reach or pass the end of the space (256 bytes) are dropped. They do not wrap to address 0.
- R6: While rst_n is low at a clock edge, these actions apply: the plain-writable and write-one-to-clear bits of bytes 4 and 5 are cleared, bytes 12 and 60 become 0, all other bytes hold their values, and any write is ignored.
- R7: stat_set bits OR into byte 7, and evt_set bits 8k+7..8k OR into byte 128+k. Only write-one-to-clear bits are affected. Other set bits are ignored.
- R8: When a set input and a write-one-to-clear write hit the same bit in the same cycle, the bit ends cleared.
- R9: rd_data is combinational. It returns the bytes starting at rd_addr, little-endian, using the size code of R4. Lanes past the size, or past the end of the space, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of write lane 0 |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write value, lane 0 in bits 7:0 |
| stat_set | input | 8 | Event set bits for status byte 7 |
| evt_set | input | 32 | Event set bits for bytes 128..131 |
| rd_addr | input | 8 | Byte address of read lane 0 |
| rd_size | input | 2 | Read size code |
| rd_data | output | 32 | Assembled read data |

## Verification
Some properties are checked by the assertions on every cycle:
- a single-byte write to the cache-line byte lands exactly;
- a write-one-to-clear write to the status byte always leaves those bits low, even against a simultaneous set;
- a set on the status byte is visible on the next cycle;
- storage stays still when nothing drives it;
- reset leaves the command, cache-line and interrupt-line bits clear;
- the tail of a read at the last address is zero.

Other behaviour only the bench scenarios can show:
- lane ordering and the no-wrap drop at the top of the space;
- that size code 3 writes nothing;
- that identity bytes resist writes;
- that reset preserves device-specific and event bytes;
- that random interleavings of writes, sets and resets agree with a byte-level reference model.

// File: rtl/cfg_space_pkg.sv
// Layout and mask definitions for the configuration space register file.
// Assumes a space of at most 256 bytes. All masks are elaboration constants.
package cfg_space_pkg;

    localparam int CMD_LO    = 4;
    localparam int CMD_HI    = 5;
    localparam int STAT_LO   = 6;
    localparam int STAT_HI   = 7;
    localparam int CLS_OFF   = 12;
    localparam int INTL_OFF  = 60;
    localparam int EVT_BASE  = 128;
    localparam int EVT_BYTES = 4;

    typedef enum logic [1:0] {
        RST_KEEP = 2'd0,
        RST_CMD  = 2'd1,
        RST_ZERO = 2'd2
    } rst_kind_e;

    // Plain read/write bits of a byte.
    function automatic logic [7:0] wmask_of(int a);
        if (a == CMD_LO)                  return 8'h07;
        if (a == CMD_HI)                  return 8'h05;
        if (a == CLS_OFF || a == INTL_OFF) return 8'hFF;
        if (a >= 64 && a <= 127)          return 8'hFF;
        if (a >= 192 && a <= 255)         return 8'hFF;
        return 8'h00;
    endfunction

    // Write-one-to-clear bits of a byte.
    function automatic logic [7:0] w1c_of(int a);
        if (a == CMD_HI)                                return 8'h80;
        if (a == STAT_HI)                               return 8'hF9;
        if (a >= EVT_BASE && a < EVT_BASE + EVT_BYTES)  return 8'hFF;
        return 8'h00;
    endfunction

    // Constant value of a byte that holds no storage.
    function automatic logic [7:0] const_of(int a, logic [15:0] vid, logic [15:0] did);
        case (a)
            0:       return vid[7:0];
            1:       return vid[15:8];
            2:       return did[7:0];
            3:       return did[15:8];
            STAT_LO: return 8'h10;
            default: return 8'h00;
        endcase
    endfunction

    // What the device reset does to a byte.
    function automatic rst_kind_e rst_kind_of(int a);
        if (a == CMD_LO || a == CMD_HI)    return RST_CMD;
        if (a == CLS_OFF || a == INTL_OFF) return RST_ZERO;
        return RST_KEEP;
    endfunction

    // Byte count for a size code. Code 3 means no bytes.
    function automatic int size_bytes(logic [1:0] sz);
        case (sz)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_wr_lane.sv
// Write lane decode for one byte of the space.
// Decides whether the current write reaches byte BYTE_IDX, and which lane of
// wr_data it takes. There is no wrap-around, so lanes past the last byte never
// hit any byte.
module cfg_wr_lane
    import cfg_space_pkg::*;
#(
    parameter int BYTE_IDX = 0,
    parameter int ADDR_W   = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [31:0]       wr_data,
    output logic              we,
    output logic [7:0]        wval
);

    int         off;
    logic [1:0] lane;

    // Offset of this byte from the start address, and the lane it selects.
    always_comb begin
        off  = BYTE_IDX - int'(wr_addr);
        lane = off[1:0];
        we   = wr_en && (off >= 0) && (off < size_bytes(wr_size));
        wval = wr_data[lane*8 +: 8];
    end

endmodule

// File: rtl/cfg_byte_cell.sv
// One configuration byte with a plain write mask and a write-one-to-clear mask.
// Bytes with neither mask hold no storage and drive a constant.
// Assumes the two masks are disjoint; an overlap is rejected at elaboration.
module cfg_byte_cell
    import cfg_space_pkg::*;
#(
    parameter logic [7:0] WMASK = 8'h00,
    parameter logic [7:0] W1C   = 8'h00,
    parameter logic [7:0] CVAL  = 8'h00,
    parameter rst_kind_e  RKIND = RST_KEEP
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wval,
    input  logic [7:0] hw_set,
    output logic [7:0] q
);

    if ((WMASK & W1C) != 8'h00) begin : g_mask_clash
        $error("cfg_byte_cell: write mask and W1C mask overlap");
    end

    if ((WMASK | W1C) == 8'h00) begin : g_const
        logic unused_ok;
        // Read-only byte: constant value, inputs ignored.
        assign unused_ok = ^{clk, rst_n, we, wval, hw_set};
        assign q = CVAL;
    end else begin : g_store
        logic [7:0] q_r;
        logic [7:0] merged;
        logic [7:0] clr;
        logic [7:0] nxt;

        // Merge write data, OR in hardware sets, then apply W1C clears last.
        always_comb begin
            merged = we ? ((q_r & ~WMASK) | (wval & WMASK)) : q_r;
            clr    = we ? (wval & W1C) : 8'h00;
            nxt    = (merged | (hw_set & W1C)) & ~clr;
        end

        // Register update with the byte's own reset action.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                case (RKIND)
                    RST_CMD:  q_r <= q_r & ~(WMASK | W1C);
                    RST_ZERO: q_r <= 8'h00;
                    default:  q_r <= q_r;
                endcase
            end else begin
                q_r <= nxt;
            end
        end

        assign q = q_r;
    end

endmodule

// File: rtl/cfg_rd_assemble.sv
// Combinational read assembly.
// Builds a little-endian word of 1, 2 or 4 bytes from the flat byte store.
// Lanes past the size code or past the end of the space read zero.
module cfg_rd_assemble
    import cfg_space_pkg::*;
#(
    parameter int SPACE_BYTES = 256,
    parameter int ADDR_W      = 8
) (
    input  logic [SPACE_BYTES*8-1:0] cfg_q,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [1:0]               rd_size,
    output logic [31:0]              rd_data
);

    // Select each lane, blanking lanes that are out of size or out of space.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < 4; k++) begin
            int idx;
            int sel;
            idx = int'(rd_addr) + k;
            sel = (idx < SPACE_BYTES) ? idx : 0;
            if (k < size_bytes(rd_size) && idx < SPACE_BYTES)
                rd_data[k*8 +: 8] = cfg_q[sel*8 +: 8];
        end
    end

endmodule

// File: rtl/cfg_space_regfile.sv
// Configuration space register file, top level.
// One lane decoder and one byte cell per byte, with set inputs routed to the
// status and event bytes, and a combinational read port. Masks come from
// cfg_space_pkg. SPACE_BYTES must not exceed 256.
module cfg_space_regfile
    import cfg_space_pkg::*;
#(
    parameter int          SPACE_BYTES = 256,
    parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID   = 16'h0417,
    localparam int         ADDR_W      = $clog2(SPACE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        stat_set,
    input  logic [31:0]       evt_set,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_size,
    output logic [31:0]       rd_data
);

    logic [SPACE_BYTES*8-1:0] cfg_q;

    for (genvar i = 0; i < SPACE_BYTES; i++) begin : g_byte
        logic       we;
        logic [7:0] wval;
        logic [7:0] hset;

        // Route the hardware set inputs that belong to this byte.
        if (i == STAT_HI) begin : g_stat
            assign hset = stat_set;
        end else if (i >= EVT_BASE && i < EVT_BASE + EVT_BYTES) begin : g_evt
            assign hset = evt_set[8*(i-EVT_BASE) +: 8];
        end else begin : g_noset
            assign hset = 8'h00;
        end

        cfg_wr_lane #(
            .BYTE_IDX (i),
            .ADDR_W   (ADDR_W)
        ) u_lane (
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_size (wr_size),
            .wr_data (wr_data),
            .we      (we),
            .wval    (wval)
        );

        cfg_byte_cell #(
            .WMASK (wmask_of(i)),
            .W1C   (w1c_of(i)),
            .CVAL  (const_of(i, VENDOR_ID, DEVICE_ID)),
            .RKIND (rst_kind_of(i))
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (we),
            .wval   (wval),
            .hw_set (hset),
            .q      (cfg_q[8*i +: 8])
        );
    end

    cfg_rd_assemble #(
        .SPACE_BYTES (SPACE_BYTES),
        .ADDR_W      (ADDR_W)
    ) u_rd (
        .cfg_q   (cfg_q),
        .rd_addr (rd_addr),
        .rd_size (rd_size),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cfg_space_checker.sv
// Assertion checker for cfg_space_regfile, attached by bind.
// Watches the ports and the flat byte store.
module cfg_space_checker
    import cfg_space_pkg::*;
#(
    parameter int SPACE_BYTES = 256,
    localparam int ADDR_W     = $clog2(SPACE_BYTES)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [1:0]               wr_size,
    input logic [31:0]              wr_data,
    input logic [7:0]               stat_set,
    input logic [31:0]              evt_set,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [1:0]               rd_size,
    input logic [31:0]              rd_data,
    input logic [SPACE_BYTES*8-1:0] cfg_q
);

    localparam logic [7:0] STAT_W1C = w1c_of(STAT_HI);
    localparam logic [7:0] CMDL_M   = wmask_of(CMD_LO) | w1c_of(CMD_LO);
    localparam logic [7:0] CMDH_M   = wmask_of(CMD_HI) | w1c_of(CMD_HI);

    logic rd_unused;
    assign rd_unused = ^{rd_size, evt_set[0]};

    // R1: a single-byte write to the cache-line byte lands exactly.
    p_write_merge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CLS_OFF) && wr_size == 2'd0)
        |=> (cfg_q[8*CLS_OFF +: 8] == $past(wr_data[7:0])));

    // R1: nothing driven, nothing changes.
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && stat_set == 8'h00 && evt_set == 32'h0) |=> $stable(cfg_q));

    // R2 and R8: ones written to status W1C bits end cleared, sets notwithstanding.
    p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(STAT_HI) && wr_size == 2'd0)
        |=> ((cfg_q[8*STAT_HI +: 8] & $past(wr_data[7:0] & STAT_W1C)) == 8'h00));

    // R7: a status set without a write is visible on the next cycle.
    p_hw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ((cfg_q[8*STAT_HI +: 8] & $past(stat_set & STAT_W1C))
                      == $past(stat_set & STAT_W1C)));

    // R6: after a reset cycle the command, cache-line and interrupt-line bits are clear.
    p_reset_clear_r6: assert property (@(posedge clk)
        (!rst_n) |=> (cfg_q[8*CLS_OFF +: 8] == 8'h00 && cfg_q[8*INTL_OFF +: 8] == 8'h00
                      && (cfg_q[8*CMD_LO +: 8] & CMDL_M) == 8'h00
                      && (cfg_q[8*CMD_HI +: 8] & CMDH_M) == 8'h00));

    // R9: a read starting at the last byte has zero upper lanes.
    p_read_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(SPACE_BYTES - 1)) |-> (rd_data[31:8] == 24'h0));

endmodule

bind cfg_space_regfile cfg_space_checker #(.SPACE_BYTES(SPACE_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_size  (wr_size),
    .wr_data  (wr_data),
    .stat_set (stat_set),
    .evt_set  (evt_set),
    .rd_addr  (rd_addr),
    .rd_size  (rd_size),
    .rd_data  (rd_data),
    .cfg_q    (cfg_q)
);

// File: tb/tb_cfg_space_regfile.sv
// Self-checking bench for cfg_space_regfile.
// Directed corner cases first, then seeded random traffic compared with a
// byte-level reference model built from the requirements.
module tb_cfg_space_regfile;

    localparam logic [15:0] VID = 16'hC0DE;
    localparam logic [15:0] DID = 16'h0417;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [1:0]  wr_size;
    logic [31:0] wr_data;
    logic [7:0]  stat_set;
    logic [31:0] evt_set;
    logic [7:0]  rd_addr;
    logic [1:0]  rd_size;
    logic [31:0] rd_data;

    always #4 clk = ~clk;

    cfg_space_regfile #(.VENDOR_ID(VID), .DEVICE_ID(DID)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .stat_set(stat_set),
        .evt_set(evt_set), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;
    logic [7:0] mdl [0:255];

    // Plain-writable bits, as given in R1.
    function automatic logic [7:0] tb_wm(int a);
        if (a == 4) return 8'h07;
        if (a == 5) return 8'h05;
        if (a == 12 || a == 60) return 8'hFF;
        if ((a >= 64 && a <= 127) || (a >= 192 && a <= 255)) return 8'hFF;
        return 8'h00;
    endfunction

    // Write-one-to-clear bits, as given in R2.
    function automatic logic [7:0] tb_w1c(int a);
        if (a == 5) return 8'h80;
        if (a == 7) return 8'hF9;
        if (a >= 128 && a <= 131) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic int tb_n(logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    endfunction

    // One clock of the model: merge, set, then clear.
    function automatic void mdl_step(bit en, int addr, logic [1:0] sz, logic [31:0] d,
                                     logic [7:0] st, logic [31:0] ev);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b;
            logic [7:0] hs;
            logic [7:0] clr;
            logic [7:0] v;
            b = mdl[a]; hs = 8'h00; clr = 8'h00;
            if (a == 7) hs = st;
            if (a >= 128 && a <= 131) hs = ev[8*(a-128) +: 8];
            if (en && a >= addr && (a - addr) < tb_n(sz)) begin
                v   = d[8*(a-addr) +: 8];
                b   = (b & ~tb_wm(a)) | (v & tb_wm(a));
                clr = v & tb_w1c(a);
            end
            mdl[a] = (b | (hs & tb_w1c(a))) & ~clr;
        end
    endfunction

    function automatic logic [31:0] mdl_read(int addr, logic [1:0] sz);
        logic [31:0] r;
        r = 32'h0;
        for (int k = 0; k < 4; k++)
            if (k < tb_n(sz) && addr + k < 256) r[8*k +: 8] = mdl[addr + k];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(bit en, int addr, logic [1:0] sz, logic [31:0] d,
                         logic [7:0] st, logic [31:0] ev);
        @(negedge clk);
        wr_en = en; wr_addr = 8'(addr); wr_size = sz; wr_data = d;
        stat_set = st; evt_set = ev;
        @(posedge clk);
        mdl_step(en, addr, sz, d, st, ev);
    endtask

    task automatic rd_check(string req, int addr, logic [1:0] sz);
        @(negedge clk);
        wr_en = 0; stat_set = 0; evt_set = 0;
        rd_addr = 8'(addr); rd_size = sz;
        #1;
        check(req, rd_data, mdl_read(addr, sz));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 1; wr_addr = 8'd12; wr_size = 2'd0; wr_data = 32'hFF;
        stat_set = 0; evt_set = 0;
        @(posedge clk);
        mdl[4] = mdl[4] & ~(tb_wm(4) | tb_w1c(4));
        mdl[5] = mdl[5] & ~(tb_wm(5) | tb_w1c(5));
        mdl[12] = 8'h00;
        mdl[60] = 8'h00;
        @(negedge clk);
        rst_n = 1; wr_en = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
        mdl[0] = VID[7:0]; mdl[1] = VID[15:8]; mdl[2] = DID[7:0]; mdl[3] = DID[15:8];
        mdl[6] = 8'h10;
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_size = 0; wr_data = 0;
        stat_set = 0; evt_set = 0; rd_addr = 0; rd_size = 0;
        do_reset();

        // Reset state and identity bytes (R6, R3).
        rd_check("R3 ids", 0, 2'd2);
        check("R3 id value", rd_data, {DID, VID});
        rd_check("R6 cmd/status after reset", 4, 2'd2);
        check("R6 cmd word", rd_data, 32'h0010_0000);

        // R1: command bytes take only their writable bits.
        drive(1, 4, 2'd1, 32'h0000_FFFF, 0, 0);
        rd_check("R1 cmd mask", 4, 2'd1);
        check("R1 cmd value", rd_data, 32'h0000_0507);

        // R7: status set with bits outside the W1C mask.
        drive(0, 0, 2'd0, 0, 8'hFF, 0);
        rd_check("R7 status set", 6, 2'd1);
        check("R7 status value", rd_data, 32'h0000_F910);

        // R2: clear two status bits.
        drive(1, 7, 2'd0, 32'h09, 0, 0);
        rd_check("R2 w1c clear", 7, 2'd0);
        check("R2 status value", rd_data, 32'h0000_00F0);

        // R8: clear beats a same-cycle set.
        drive(0, 0, 2'd0, 0, 8'hFF, 0);
        drive(1, 7, 2'd0, 32'h08, 8'h08, 0);
        rd_check("R8 clear wins", 7, 2'd0);
        check("R8 status value", rd_data, 32'h0000_00F1);

        // R4 and R9: four-byte lane order, then an unaligned two-byte read.
        drive(1, 64, 2'd2, 32'h4433_2211, 0, 0);
        rd_check("R4 lanes", 64, 2'd2);
        check("R4 lane value", rd_data, 32'h4433_2211);
        rd_check("R9 unaligned read", 65, 2'd1);
        check("R9 read value", rd_data, 32'h0000_3322);

        // R4: size code 3 writes nothing.
        drive(1, 64, 2'd3, 32'hDEAD_BEEF, 0, 0);
        rd_check("R4 size3 no write", 64, 2'd2);

        // R5: top-of-space write drops the upper lanes without wrapping.
        drive(1, 253, 2'd2, 32'hAABB_CCDD, 0, 0);
        rd_check("R5 top drop", 253, 2'd2);
        check("R5 top value", rd_data, 32'h00BB_CCDD);
        rd_check("R5 no wrap", 0, 2'd2);

        // R3: writes to read-only bytes have no effect.
        drive(1, 0, 2'd2, 32'hFFFF_FFFF, 0, 0);
        drive(1, 16, 2'd2, 32'hFFFF_FFFF, 0, 0);
        rd_check("R3 ro ids", 0, 2'd2);
        check("R3 ro id value", rd_data, {DID, VID});
        rd_check("R3 ro zero", 16, 2'd2);

        // R7 and R2: event bytes set, then partly cleared.
        drive(0, 0, 2'd0, 0, 0, 32'h8001_FF10);
        drive(1, 128, 2'd2, 32'h8000_0F10, 0, 0);
        rd_check("R7 evt set/clear", 128, 2'd2);
        check("R7 evt value", rd_data, 32'h0001_F000);

        // R6: reset clears cls, intl and cmd, keeps the other stored bytes.
        drive(1, 12, 2'd0, 32'h55, 0, 0);
        drive(1, 60, 2'd0, 32'h66, 0, 0);
        do_reset();
        rd_check("R6 cls", 12, 2'd0);
        rd_check("R6 intl", 60, 2'd0);
        rd_check("R6 cmd", 4, 2'd1);
        rd_check("R6 keep dev", 64, 2'd2);
        rd_check("R6 keep status", 7, 2'd0);
        check("R6 status kept", rd_data, 32'h0000_00F1);

        // Random traffic against the model (R1, R2, R4, R5, R7, R8, R9).
        for (int it = 0; it < 3000; it++) begin
            int          pick;
            int          addr;
            logic [7:0]  st;
            logic [31:0] ev;
            pick = $urandom_range(0, 99);
            case ($urandom_range(0, 5))
                0:       addr = $urandom_range(4, 7);
                1:       addr = $urandom_range(126, 133);
                2:       addr = $urandom_range(250, 255);
                3:       addr = (($urandom_range(0, 1) == 0) ? 12 : 60);
                default: addr = $urandom_range(0, 255);
            endcase
            st = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            ev = ($urandom_range(0, 3) == 0) ? $urandom : 32'h0;
            if (pick < 2) do_reset();
            else drive(pick < 80, addr, 2'($urandom_range(0, 3)), $urandom, st, ev);
            rd_check("R9 random read", $urandom_range(0, 255), 2'($urandom_range(0, 3)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule